// File: doc/BRIEF.md
# Memory-Hard Hash Block Compression Engine

This engine computes the block compression step of a memory-hard password hash. It takes two 1024-byte blocks, each seen as 128 words of 64 bits, and produces one 1024-byte block. The engine first fetches both operands word by word and keeps their bitwise XOR (called R) in an internal store. It copies R into a working array. It then runs a sixteen-word permutation P over each of the eight row groups of that array, and after that over each of the eight column groups. The result is written out word by word as the permuted array XOR R.

The surrounding design owns the block memory and chooses which blocks take part. It pulses `start` and provides read data for the addresses the engine drives, combinationally in the same cycle. It then receives 128 write strobes in ascending address order, followed by a one-cycle `done` pulse.

The controller is a single state machine with these states:
- IDLE: waits for `start`, then goes to LOAD.
- LOAD: 128 cycles, one word fetched per cycle, then goes to GATHER.
- GATHER: copies one sixteen-word group into the vector register, then goes to MIX_COL.
- MIX_COL: applies the column half-round, then goes to MIX_DIAG.
- MIX_DIAG: applies the diagonal half-round, then goes to SCATTER.
- SCATTER: writes the group back. After the eighth column group it goes to DRAIN; otherwise it returns to GATHER for the next group.
- DRAIN: 128 output writes, then goes to FINISH.
- FINISH: raises `done` for one cycle, then returns to IDLE.

Top module: `argon_g_core`

## Requirements
- R1: While reset is asserted, and in IDLE after reset, `done` and `wr_en` are 0.
- R2: The cycle after `start` is sampled in IDLE, the engine begins reading. It drives addresses 0,1,...,127 on both `x_addr` and `y_addr` in 128 consecutive cycles and captures R[i] = X[i] XOR Y[i].
- R3: Output word i equals Z[i] XOR R[i]. Z is obtained by applying P to all eight row groups of R, and then to all eight column groups of the result.
- R4: Element e (0..15) of row group g is word 16*g + e, which is address bits {g, e}. Element e of column group g is word 16*(e>>1) + 2*g + (e&1), which is address bits {e[3:1], g, e[0]}.
- R5: P is a column pass followed by a diagonal pass of a four-word mixer. The mixer uses the quads (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15), then (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14). Every addition a+b is replaced by a+b+2*lo32(a)*lo32(b), modulo 2^64. The right rotations are 32, 24, 16 and 63.
- R6: `wr_en` is high for exactly 128 consecutive cycles, with `wr_addr` running 0 to 127 in ascending order.
- R7: `done` is high for exactly one cycle. That cycle follows the 320th rising edge after the edge that sampled `start`, and it is the cycle right after the last write.
- R8: `start` has no effect while a computation is in progress. Timing, write count and results are unchanged.
- R9: Equal operands, or two all-zero operands, produce an all-zero output block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a compression (sampled in IDLE) |
| x_addr | output | 7 | Word address for operand X |
| x_rdata | input | 64 | Operand X word at `x_addr`, same cycle |
| y_addr | output | 7 | Word address for operand Y |
| y_rdata | input | 64 | Operand Y word at `y_addr`, same cycle |
| wr_en | output | 1 | Result word write strobe |
| wr_addr | output | 7 | Result word address |
| wr_data | output | 64 | Result word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the output protocol on every cycle. It checks that `done` lasts one cycle and never coincides with a write, that the write stream starts at address 0 and climbs by one, and that `done` follows the write to address 127 directly. Only the bench scenarios can show the arithmetic. These cover random operands, equal and zero operands, and an all-ones operand, and they show that the row and column grouping, the multiply-augmented mixer and the R feed-forward are right. The bench also shows that stray `start` pulses mid-run leave timing and data untouched.

// File: rtl/argon_g_pkg.sv
package argon_g_pkg;
    localparam int WORD_W  = 64;
    localparam int N_WORDS = 128;
    localparam int ADDR_W  = $clog2(N_WORDS);
    localparam int VEC_N   = 16;
    localparam int GRP_N   = N_WORDS / VEC_N;
    localparam int GRP_W   = $clog2(GRP_N);
    localparam int ELEM_W  = $clog2(VEC_N);
    localparam int HALF_W  = WORD_W / 2;

    typedef logic [WORD_W-1:0]            word_t;
    typedef logic [VEC_N-1:0][WORD_W-1:0] vec_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOAD, ST_GATHER, ST_MIX_COL,
        ST_MIX_DIAG, ST_SCATTER, ST_DRAIN, ST_FINISH
    } state_t;

    // a + b + 2*lo(a)*lo(b), modulo 2^WORD_W
    function automatic word_t mul_add(word_t a, word_t b);
        word_t prod;
        prod = word_t'(a[HALF_W-1:0]) * word_t'(b[HALF_W-1:0]);
        return a + b + (prod << 1);
    endfunction

    function automatic word_t rot_r(word_t v, int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    // word address of element e of group grp; col selects column grouping
    function automatic logic [ADDR_W-1:0] slot_addr(logic col,
                                                   logic [GRP_W-1:0] grp,
                                                   logic [ELEM_W-1:0] e);
        if (col)
            return {e[ELEM_W-1:1], grp, e[0]};
        else
            return {grp, e};
    endfunction
endpackage

// File: rtl/argon_g_mix.sv
module argon_g_mix
    import argon_g_pkg::*;
(
    input  word_t a_in,
    input  word_t b_in,
    input  word_t c_in,
    input  word_t d_in,
    output word_t a_out,
    output word_t b_out,
    output word_t c_out,
    output word_t d_out
);
    word_t a1, b1, c1, d1, a2, c2;

    always_comb begin
        a1    = mul_add(a_in, b_in);
        d1    = rot_r(d_in ^ a1, 32);
        c1    = mul_add(c_in, d1);
        b1    = rot_r(b_in ^ c1, 24);
        a2    = mul_add(a1, b1);
        d_out = rot_r(d1 ^ a2, 16);
        c2    = mul_add(c1, d_out);
        b_out = rot_r(b1 ^ c2, 63);
        a_out = a2;
        c_out = c2;
    end
endmodule

// File: rtl/argon_g_half.sv
module argon_g_half
    import argon_g_pkg::*;
#(
    parameter int LANES = 4
) (
    input  vec_t v_in,
    input  logic diag,
    output vec_t v_out
);
    localparam int IW = $clog2(VEC_N);

    function automatic logic [IW-1:0] lane_idx(int q, int row, logic dg);
        int col;
        col = dg ? ((q + row) % LANES) : q;
        return IW'(row * LANES + col);
    endfunction

    word_t oa [LANES];
    word_t ob [LANES];
    word_t oc [LANES];
    word_t od [LANES];

    for (genvar q = 0; q < LANES; q++) begin : g_lane
        argon_g_mix u_mix (
            .a_in (v_in[lane_idx(q, 0, diag)]),
            .b_in (v_in[lane_idx(q, 1, diag)]),
            .c_in (v_in[lane_idx(q, 2, diag)]),
            .d_in (v_in[lane_idx(q, 3, diag)]),
            .a_out(oa[q]),
            .b_out(ob[q]),
            .c_out(oc[q]),
            .d_out(od[q])
        );
    end

    always_comb begin
        v_out = v_in;
        for (int q = 0; q < LANES; q++) begin
            v_out[lane_idx(q, 0, diag)] = oa[q];
            v_out[lane_idx(q, 1, diag)] = ob[q];
            v_out[lane_idx(q, 2, diag)] = oc[q];
            v_out[lane_idx(q, 3, diag)] = od[q];
        end
    end
endmodule

// File: rtl/argon_g_store.sv
module argon_g_store
    import argon_g_pkg::*;
(
    input  logic              clk,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_idx,
    input  word_t             ld_word,
    input  logic              grp_col,
    input  logic [GRP_W-1:0]  grp_sel,
    output vec_t              grp_rd,
    input  logic              st_en,
    input  vec_t              st_vec,
    input  logic [ADDR_W-1:0] out_idx,
    output word_t             out_word
);
    word_t work  [N_WORDS];
    word_t resid [N_WORDS];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            work[ld_idx] <= ld_word;
        end else if (st_en) begin
            for (int e = 0; e < VEC_N; e++)
                work[slot_addr(grp_col, grp_sel, ELEM_W'(e))] <= st_vec[e];
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en)
            resid[ld_idx] <= ld_word;
    end

    always_comb begin
        for (int e = 0; e < VEC_N; e++)
            grp_rd[e] = work[slot_addr(grp_col, grp_sel, ELEM_W'(e))];
    end

    assign out_word = work[out_idx] ^ resid[out_idx];
endmodule

// File: rtl/argon_g_core.sv
module argon_g_core
    import argon_g_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] x_addr,
    input  logic [WORD_W-1:0] x_rdata,
    output logic [ADDR_W-1:0] y_addr,
    input  logic [WORD_W-1:0] y_rdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(N_WORDS - 1);
    localparam logic [GRP_W-1:0]  LAST_GRP  = GRP_W'(GRP_N - 1);

    state_t            state_q, state_d;
    logic [ADDR_W-1:0] cnt_q;
    logic [GRP_W-1:0]  grp_q;
    logic              col_q;
    vec_t              vec_q;

    vec_t  grp_rd, half_out;
    word_t out_word;
    logic  ld_en, st_en, diag;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_LOAD;
            ST_LOAD:     if (cnt_q == LAST_WORD) state_d = ST_GATHER;
            ST_GATHER:   state_d = ST_MIX_COL;
            ST_MIX_COL:  state_d = ST_MIX_DIAG;
            ST_MIX_DIAG: state_d = ST_SCATTER;
            ST_SCATTER:  state_d = (col_q && grp_q == LAST_GRP) ? ST_DRAIN : ST_GATHER;
            ST_DRAIN:    if (cnt_q == LAST_WORD) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // counters and vector register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            grp_q <= '0;
            col_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LOAD, ST_DRAIN: cnt_q <= cnt_q + 1'b1;
                ST_SCATTER: begin
                    grp_q <= grp_q + 1'b1;
                    if (grp_q == LAST_GRP) col_q <= ~col_q;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        unique case (state_q)
            ST_GATHER:              vec_q <= grp_rd;
            ST_MIX_COL, ST_MIX_DIAG: vec_q <= half_out;
            default: ;
        endcase
    end

    // outputs
    always_comb begin
        x_addr  = '0;
        y_addr  = '0;
        ld_en   = 1'b0;
        st_en   = 1'b0;
        diag    = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        done    = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                x_addr = cnt_q;
                y_addr = cnt_q;
                ld_en  = 1'b1;
            end
            ST_MIX_DIAG: diag  = 1'b1;
            ST_SCATTER:  st_en = 1'b1;
            ST_DRAIN: begin
                wr_en   = 1'b1;
                wr_addr = cnt_q;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign wr_data = out_word;

    argon_g_store u_store (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_idx  (cnt_q),
        .ld_word (x_rdata ^ y_rdata),
        .grp_col (col_q),
        .grp_sel (grp_q),
        .grp_rd  (grp_rd),
        .st_en   (st_en),
        .st_vec  (vec_q),
        .out_idx (cnt_q),
        .out_word(out_word)
    );

    argon_g_half #(.LANES(4)) u_half (
        .v_in (vec_q),
        .diag (diag),
        .v_out(half_out)
    );
endmodule

// File: rtl/argon_g_chk.sv
module argon_g_chk
    import argon_g_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done
);
    localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(N_WORDS - 1);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en); // R7

    AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R6

    AST_WR_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_addr == '0)); // R6

    AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LAST_WORD) |=> (done && !wr_en)); // R7
endmodule

bind argon_g_core argon_g_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .done   (done)
);

// File: tb/tb_argon_g_core.sv
module tb_argon_g_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  x_addr, y_addr, wr_addr;
    logic [63:0] x_rdata, y_rdata, wr_data;
    logic        wr_en, done;

    logic [63:0] xm [128];
    logic [63:0] ym [128];
    logic [63:0] got [128];
    logic [63:0] expv [128];
    logic [63:0] bv [16];

    int n_chk = 0;
    int n_fail = 0;
    int wr_seq = 0;
    bit order_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign x_rdata = xm[x_addr];
    assign y_rdata = ym[y_addr];

    argon_g_core dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_addr(x_addr), .x_rdata(x_rdata),
        .y_addr(y_addr), .y_rdata(y_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (int'(wr_addr) != wr_seq) order_bad = 1;
            got[wr_addr] = wr_data;
            wr_seq++;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    function automatic logic [63:0] bm(logic [63:0] a, logic [63:0] b);
        return a + b + 64'd2 * (64'(a[31:0]) * 64'(b[31:0]));
    endfunction

    function automatic logic [63:0] ror(logic [63:0] x, int n);
        logic [127:0] t;
        t = {x, x} >> n;
        return t[63:0];
    endfunction

    task automatic bquad(int a, int b, int c, int d);
        bv[a] = bm(bv[a], bv[b]); bv[d] = ror(bv[d] ^ bv[a], 32);
        bv[c] = bm(bv[c], bv[d]); bv[b] = ror(bv[b] ^ bv[c], 24);
        bv[a] = bm(bv[a], bv[b]); bv[d] = ror(bv[d] ^ bv[a], 16);
        bv[c] = bm(bv[c], bv[d]); bv[b] = ror(bv[b] ^ bv[c], 63);
    endtask

    // R5: column then diagonal pass
    task automatic bperm();
        bquad(0, 4, 8, 12); bquad(1, 5, 9, 13);
        bquad(2, 6, 10, 14); bquad(3, 7, 11, 15);
        bquad(0, 5, 10, 15); bquad(1, 6, 11, 12);
        bquad(2, 7, 8, 13); bquad(3, 4, 9, 14);
    endtask

    // R3, R4 reference model
    task automatic model();
        logic [63:0] r [128];
        logic [63:0] q [128];
        for (int i = 0; i < 128; i++) begin r[i] = xm[i] ^ ym[i]; q[i] = r[i]; end
        for (int g = 0; g < 8; g++) begin
            for (int e = 0; e < 16; e++) bv[e] = q[16*g + e];
            bperm();
            for (int e = 0; e < 16; e++) q[16*g + e] = bv[e];
        end
        for (int g = 0; g < 8; g++) begin
            for (int e = 0; e < 16; e++) bv[e] = q[16*(e/2) + 2*g + (e%2)];
            bperm();
            for (int e = 0; e < 16; e++) q[16*(e/2) + 2*g + (e%2)] = bv[e];
        end
        for (int i = 0; i < 128; i++) expv[i] = q[i] ^ r[i];
    endtask

    task automatic run_case(string name, string req, bit poke);
        int edges;
        int mism;
        int first_bad;
        bit addr_bad;
        model();
        wr_seq = 0; order_bad = 0; addr_bad = 0; mism = 0; first_bad = 0;
        for (int i = 0; i < 128; i++) got[i] = 64'hDEAD;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        edges = 0;
        while (!done && edges < 2000) begin
            if (edges < 128 && (int'(x_addr) != edges || int'(y_addr) != edges)) addr_bad = 1;
            start = poke && (edges == 40 || edges == 250);
            @(posedge clk); edges++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(addr_bad == 0, "R2", {name, " read address sequence"}, addr_bad, 0);
        chk(edges == 320, poke ? "R8" : "R7", {name, " done latency"}, edges, 320);
        chk(wr_seq == 128 && !order_bad, "R6", {name, " write count/order"}, wr_seq, 128);
        for (int i = 0; i < 128; i++)
            if (got[i] !== expv[i]) begin
                if (mism == 0) first_bad = i;
                mism++;
            end
        chk(mism == 0, req, {name, " result word"}, got[first_bad], expv[first_bad]);
        @(posedge clk); @(negedge clk);
        chk(done == 0, "R7", {name, " done single cycle"}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1DC0FFEE));
        for (int i = 0; i < 128; i++) begin xm[i] = '0; ym[i] = '0; end
        repeat (3) @(negedge clk);
        chk(done == 0 && wr_en == 0, "R1", "outputs during reset", {done, wr_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(done == 0 && wr_en == 0, "R1", "outputs idle after reset", {done, wr_en}, 0);

        // R9: all zero
        run_case("zeros", "R9", 0);

        // R9: equal operands
        for (int i = 0; i < 128; i++) begin xm[i] = {$urandom, $urandom}; ym[i] = xm[i]; end
        run_case("equal", "R9", 0);

        // R3/R4/R5: random operands
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 128; i++) begin xm[i] = {$urandom, $urandom}; ym[i] = {$urandom, $urandom}; end
            run_case("random", "R3", 0);
        end

        // R4: a single nonzero word exposes row/column grouping
        for (int i = 0; i < 128; i++) begin xm[i] = '0; ym[i] = '0; end
        xm[37] = 64'h0000_0001_0000_0003;
        run_case("single word", "R4", 0);

        // R5: all-ones X, zero Y stresses carries in the multiply-add
        for (int i = 0; i < 128; i++) begin xm[i] = '1; ym[i] = '0; end
        run_case("ones", "R5", 0);

        // R8: stray start pulses during a run
        for (int i = 0; i < 128; i++) begin xm[i] = {$urandom, $urandom}; ym[i] = {$urandom, $urandom}; end
        run_case("start ignored", "R8", 1);

        repeat (4) @(negedge clk);
        chk(done == 0 && wr_en == 0, "R8", "idle after stray start", {done, wr_en}, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule